// File: doc/BRIEF.md
# I2C Byte-Oriented Bus Master

This block is a single-master I2C controller commanded one byte at a time by a local processor. Each command either opens a transfer with a START condition followed by a control byte, sends a data byte, receives a data byte, or closes the transfer with a STOP condition. The control byte holds a 4-bit device-type field, then three device-select bits, then the direction bit (1 = read, 0 = write), shifted out most significant bit first. The block sends it exactly as given.

After the ninth clock of every byte the master reports the acknowledge level. It raises a completion flag and holds SCL low until the processor issues the next command. The block never acts as a slave. SCL and SDA are open-drain: a `*_oe` output of 1 pulls the line low. The block watches both lines. If it has released a line and finds it low at a point where no other device may drive it, it flags a bus fault, abandons the transfer and releases both lines. This is how a second master shows up. The block does not arbitrate.

The SCL period is `DIV` system clocks, split into four equal quarters. The default of 132 gives about 90.9 kHz from a 12 MHz clock.

Top module: `i2c_master`

## Requirements
- R1: After reset, both lines are released (`scl_oe` = `sda_oe` = 0) and `busy`, `done`, `nack` and `bus_fault` are all 0.
- R2: A START command (`cmd_op` = 0) is accepted while the block is idle or holding the bus between bytes. SDA falls while SCL is high, and then the 8 bits of `cmd_data` go out MSB first. Bit 0 is the direction bit and is sent unchanged. A START issued while holding the bus produces a repeated START.
- R3: The SCL period is `DIV` clocks (1056 ns at the default 132 on an 8 ns clock), and SCL is high for `DIV/2` of them.
- R4: SDA changes only while SCL is low. The exceptions are the START edge (SDA falling), the STOP edge (SDA rising) and the release of both lines after a fault.
- R5: On the ninth clock of every byte, the master samples SDA and latches it into `nack` (0 = acknowledged). During the ninth clock of a START or write byte (`cmd_op` = 0 or 1), the master leaves SDA released.
- R6: A read command (`cmd_op` = 2) leaves SDA released for eight clocks and assembles the sampled bits MSB first on `rd_data`. On the ninth clock the master drives SDA low, unless `cmd_last` was 1, in which case SDA stays high.
- R7: `done` rises one clock before SCL falls after the ninth clock. SCL then stays low, with no further bus activity, until the next accepted command. Accepting a command clears `done`.
- R8: A STOP command (`cmd_op` = 3) raises SDA while SCL is high. Afterwards both lines are released, `busy` is 0 and `done` is 1.
- R9: If a released line reads low at a check point, the block sets `bus_fault` and `done` and returns to idle. The check points are: both lines before START, SCL during its high quarters, and SDA while this master sends a 1. Both lines are released one clock after `bus_fault` rises. The next accepted START clears `bus_fault`.
- R10: The block ignores commands while `busy` is 1. It also ignores write, read and STOP commands while no transfer is open, meaning the block is idle rather than holding the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 0 START+byte, 1 write byte, 2 read byte, 3 STOP |
| cmd_data | input | 8 | Control or data byte to send |
| cmd_last | input | 1 | Read only: last byte, answer with no-acknowledge |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | A START, byte or STOP sequence is running |
| done | output | 1 | Last command finished or was aborted |
| nack | output | 1 | SDA level sampled on the last ninth clock |
| bus_fault | output | 1 | Foreign drive detected; sticky until next START |
| rd_data | output | 8 | Byte assembled during the last read |

## Verification
Bus results are due at SCL and SDA edges, so the bench waits on those edges and samples one nanosecond later. Data bits are read at each SCL rise, and the START and STOP edges are checked against the SCL level at the moment SDA moves. `done` is due one clock before the SCL fall that ends the ninth clock. The bench checks that `done` is still 0 at the ninth rise and is 1 just after that fall. A fault is due by the end of the quarter in which the foreign drive appears, and the released lines follow one clock later. The bench therefore waits a bounded number of clocks for `done`, and then checks the lines after one further clock.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2,
      OP_STOP  = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_BIT,
      ST_HOLD,
      ST_STOP
   } state_e;

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
   parameter int unsigned DIV = 132
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int unsigned QTR = DIV / 4;
   localparam int unsigned CW  = $clog2(QTR);

   if (DIV % 4 != 0 || DIV < 8) begin : g_bad_div
      $error("i2cm_tick: DIV must be a multiple of 4 and at least 8");
   end

   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap = (cnt == CW'(QTR - 1));
   assign tick = run && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!run || wrap)  cnt <= '0;
      else                    cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES > 4) begin : g_bad_stages
      $error("i2cm_sync: STAGES above 4 is not supported");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ff <= '1;
         end else begin
            ff[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) ff[i] <= ff[i-1];
         end
      end
      assign q = ff[STAGES-1];
   end
endmodule

// File: rtl/i2cm_shreg.sv
module i2cm_shreg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         sin,
   output logic [W-1:0] q
);
   if (W < 2) begin : g_bad_w
      $error("i2cm_shreg: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (load)  q <= load_val;
      else if (shift) q <= {q[W-2:0], sin};
   end
endmodule

// File: rtl/i2c_master.sv
module i2c_master
   import i2cm_pkg::*;
#(
   parameter int unsigned DIV         = 132,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_op,
   input  logic [7:0] cmd_data,
   input  logic       cmd_last,
   input  logic       scl_in,
   input  logic       sda_in,
   output logic       scl_oe,
   output logic       sda_oe,
   output logic       busy,
   output logic       done,
   output logic       nack,
   output logic       bus_fault,
   output logic [7:0] rd_data
);
   localparam int unsigned BW = $clog2(BYTE_W + 1);

   state_e           st;
   logic [1:0]       q;
   logic [BW-1:0]    bitn;
   logic             rd_mode, last_rd, from_hold, samp;
   logic             scl_s, sda_s, tick, run, accept;
   logic             scl_d, sda_d, sda_keep, drive_one, err, ack_bit;
   logic             sh_load, sh_shift;
   logic [BYTE_W-1:0] sh_val, sh_q;
   op_e              op;

   i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (.clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
   i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (.clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));
   i2cm_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .run(run), .tick(tick));

   assign op      = op_e'(cmd_op);
   assign run     = (st == ST_START) || (st == ST_BIT) || (st == ST_STOP);
   assign busy    = run;
   assign accept  = cmd_valid && !run && (op == OP_START || st == ST_HOLD);
   assign ack_bit = (bitn == BW'(BYTE_W));
   assign drive_one = ack_bit ? (rd_mode && last_rd) : (!rd_mode && sh_q[BYTE_W-1]);

   assign sh_load  = accept && (op != OP_STOP);
   assign sh_val   = (op == OP_READ) ? '1 : cmd_data;
   assign sh_shift = tick && !err && (st == ST_BIT) && (q == 2'd3) && !ack_bit;

   i2cm_shreg #(.W(BYTE_W)) u_shreg (
      .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val),
      .shift(sh_shift), .sin(samp), .q(sh_q)
   );
   assign rd_data = sh_q;

   // line drive per state and quarter; SDA moves only in quarter 1 of a bit
   always_comb begin
      scl_d    = 1'b0;
      sda_d    = 1'b0;
      sda_keep = 1'b0;
      unique case (st)
         ST_START: begin
            scl_d = (q == 2'd0) ? from_hold : (q == 2'd3);
            sda_d = q[1];
         end
         ST_BIT: begin
            scl_d    = !q[1];
            sda_keep = (q == 2'd0);
            sda_d    = ack_bit ? (rd_mode && !last_rd) : (!rd_mode && !sh_q[BYTE_W-1]);
         end
         ST_HOLD: begin
            scl_d    = 1'b1;
            sda_keep = 1'b1;
         end
         ST_STOP: begin
            scl_d = !q[1];
            sda_d = (q != 2'd3);
         end
         default: ;
      endcase
   end

   // foreign-drive detection at the end of a quarter
   always_comb begin
      unique case (st)
         ST_START: err = (q == 2'd1) && (!scl_s || !sda_s);
         ST_BIT:   err = q[1] && (!scl_s || (drive_one && !sda_s));
         ST_STOP:  err = q[1] && (!scl_s || (q[0] && !sda_s));
         default:  err = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;  q <= '0;  bitn <= '0;
         rd_mode <= 1'b0;  last_rd <= 1'b0;  from_hold <= 1'b0;  samp <= 1'b0;
         done <= 1'b0;  nack <= 1'b0;  bus_fault <= 1'b0;
         scl_oe <= 1'b0;  sda_oe <= 1'b0;
      end else begin
         scl_oe <= scl_d;
         if (!sda_keep) sda_oe <= sda_d;
         if (accept) begin
            done <= 1'b0;
            q    <= '0;
            bitn <= '0;
            unique case (op)
               OP_START: begin
                  st <= ST_START;  from_hold <= (st == ST_HOLD);
                  rd_mode <= 1'b0;  bus_fault <= 1'b0;
               end
               OP_WRITE: begin st <= ST_BIT; rd_mode <= 1'b0; end
               OP_READ:  begin st <= ST_BIT; rd_mode <= 1'b1; last_rd <= cmd_last; end
               default:  st <= ST_STOP;
            endcase
         end else if (tick) begin
            if (err) begin
               st <= ST_IDLE;  bus_fault <= 1'b1;  done <= 1'b1;
            end else begin
               q <= q + 2'd1;
               unique case (st)
                  ST_START: if (q == 2'd3) begin st <= ST_BIT; bitn <= '0; end
                  ST_BIT: begin
                     if (q == 2'd2) begin
                        samp <= sda_s;
                        if (ack_bit) nack <= sda_s;
                     end
                     if (q == 2'd3) begin
                        if (ack_bit) begin st <= ST_HOLD; done <= 1'b1; end
                        else         bitn <= bitn + BW'(1);
                     end
                  end
                  ST_STOP: if (q == 2'd3) begin st <= ST_IDLE; done <= 1'b1; end
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk
   import i2cm_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input logic   cmd_valid,
   input logic   scl_oe,
   input logic   sda_oe,
   input logic   busy,
   input logic   done,
   input logic   bus_fault,
   input state_e st
);
   // R4: SDA pulled low with SCL released on both cycles only as a START
   p_start_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_oe && !$past(scl_oe) && $rose(sda_oe)) |-> ($past(st) == ST_START));

   // R4: SDA let go with SCL released only as a STOP or a fault release
   p_stop_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_oe && !$past(scl_oe) && $fell(sda_oe)) |-> ($past(st) == ST_STOP || bus_fault));

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_hold_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD && $past(st) == ST_HOLD) |-> scl_oe);

   p_fault_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_fault) |=> (!scl_oe && !sda_oe));

   p_fault_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_fault) |-> $past(cmd_valid));

   p_busy_by_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid));
endmodule

bind i2c_master i2cm_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .scl_oe(scl_oe), .sda_oe(sda_oe),
   .busy(busy), .done(done), .bus_fault(bus_fault), .st(st)
);

// File: tb/i2c_master_tb.sv
module i2c_master_tb;
   import i2cm_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic [7:0] cmd_data = 8'h00;
   logic       cmd_last = 1'b0;
   logic       slv_scl_low = 1'b0, slv_sda_low = 1'b0;
   logic       scl_oe, sda_oe, busy, done, nack, bus_fault;
   logic [7:0] rd_data;
   wire        scl_bus = !scl_oe && !slv_scl_low;
   wire        sda_bus = !sda_oe && !slv_sda_low;

   int n_chk = 0, n_fail = 0, r4_viol = 0;
   bit allow = 1'b1;
   bit ended = 1'b0;

   i2c_master u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_data(cmd_data), .cmd_last(cmd_last), .scl_in(scl_bus), .sda_in(sda_bus),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done), .nack(nack),
      .bus_fault(bus_fault), .rd_data(rd_data)
   );

   always @(sda_bus) if (!allow && scl_bus) r4_viol++;

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic issue(input op_e op, input logic [7:0] d, input logic last);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_last = last;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_done(input int maxc);
      for (int i = 0; i < maxc && !done; i++) @(negedge clk);
   endtask

   task automatic byte_out(input logic ack, output logic [7:0] got, output logic s9,
                           output longint per, output longint hi);
      longint t0 = 0, t1 = 0, t2 = 0;
      logic d9;
      for (int i = 0; i < 8; i++) begin
         @(posedge scl_bus);
         if (i == 0) t0 = $time;
         if (i == 1) t1 = $time;
         #1 got[7-i] = sda_bus;
         @(negedge scl_bus);
         if (i == 0) t2 = $time;
         #1 if (i == 7) slv_sda_low = ack;
      end
      @(posedge scl_bus); #1 s9 = sda_bus; d9 = done;
      @(negedge scl_bus); #1 slv_sda_low = 1'b0;
      chk("R7 done low during ninth clock", d9, 0);
      chk("R7 done high as SCL falls", done, 1);
      per = t1 - t0;
      hi  = t2 - t0;
   endtask

   task automatic start_byte(input logic [7:0] addr, input logic ack, output logic [7:0] got,
                             output logic s9, output longint per, output longint hi);
      allow = 1'b1;
      issue(OP_START, addr, 1'b0);
      @(negedge sda_bus); #1;
      chk("R2 START: SCL high at SDA fall", scl_bus, 1);
      allow = 1'b0;
      byte_out(ack, got, s9, per, hi);
   endtask

   task automatic byte_in(input logic [7:0] val, input logic last, output logic s9);
      slv_sda_low = !val[7];
      issue(OP_READ, 8'h00, last);
      for (int i = 0; i < 8; i++) begin
         @(posedge scl_bus);
         @(negedge scl_bus); #1;
         if (i < 7) slv_sda_low = !val[6-i];
         else       slv_sda_low = 1'b0;
      end
      @(posedge scl_bus); #1 s9 = sda_bus;
      @(negedge scl_bus); #1;
      chk("R7 done after read byte", done, 1);
   endtask

   task automatic stop_seq();
      allow = 1'b1;
      issue(OP_STOP, 8'h00, 1'b0);
      @(posedge sda_bus); #1;
      chk("R8 STOP: SCL high at SDA rise", scl_bus, 1);
      allow = 1'b0;
      wait_done(200);
      chk("R8 done after STOP", done, 1);
      chk("R8 busy after STOP", busy, 0);
      @(negedge clk);
      chk("R8 lines released after STOP", {scl_oe, sda_oe}, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 scl_oe/sda_oe after reset", {scl_oe, sda_oe}, 0);
      chk("R1 busy/done after reset", {busy, done}, 0);
      chk("R1 nack/bus_fault after reset", {nack, bus_fault}, 0);
      allow = 1'b0;
   endtask

   task automatic t_ignore_idle();
      issue(OP_WRITE, 8'h55, 1'b0);
      chk("R10 write ignored when idle: busy", busy, 0);
      issue(OP_READ, 8'h00, 1'b0);
      issue(OP_STOP, 8'h00, 1'b0);
      repeat (300) @(negedge clk);
      chk("R10 idle commands: bus untouched", {scl_bus, sda_bus}, 2'b11);
      chk("R10 idle commands: busy/done", {busy, done}, 0);
   endtask

   task automatic t_write();
      logic [7:0] got; logic s9; longint per, hi;
      start_byte(8'hA4, 1'b1, got, s9, per, hi);
      chk("R2 control byte MSB first, dir 0", got, 8'hA4);
      chk("R3 SCL period", per, 132 * 8);
      chk("R3 SCL high time", hi, 66 * 8);
      chk("R5 acknowledged: nack", nack, 0);
      repeat (300) @(negedge clk);
      chk("R7 SCL held low between bytes", scl_bus, 0);
      chk("R7 not busy while holding", busy, 0);
      issue(OP_WRITE, 8'h3C, 1'b0);
      chk("R10 busy after write accepted", busy, 1);
      issue(OP_WRITE, 8'hFF, 1'b0);
      byte_out(1'b0, got, s9, per, hi);
      chk("R10 command while busy ignored: data", got, 8'h3C);
      chk("R5 SDA released on ninth clock of write", s9, 1);
      chk("R5 no acknowledge: nack", nack, 1);
      stop_seq();
   endtask

   task automatic t_read();
      logic [7:0] got; logic s9; longint per, hi;
      start_byte(8'hA4, 1'b1, got, s9, per, hi);
      start_byte(8'hA5, 1'b1, got, s9, per, hi);
      chk("R2 repeated START byte, dir 1", got, 8'hA5);
      byte_in(8'h96, 1'b0, s9);
      chk("R6 read data", rd_data, 8'h96);
      chk("R6 master ack low", s9, 0);
      chk("R5 nack after acked read", nack, 0);
      byte_in(8'h5A, 1'b1, s9);
      chk("R6 read data last byte", rd_data, 8'h5A);
      chk("R6 last byte left high", s9, 1);
      chk("R5 nack after last read", nack, 1);
      stop_seq();
   endtask

   task automatic t_fault_start();
      allow = 1'b1;
      slv_sda_low = 1'b1;
      issue(OP_START, 8'hA4, 1'b0);
      wait_done(200);
      chk("R9 fault on busy bus before START", bus_fault, 1);
      chk("R9 done/busy after fault", {done, busy}, 2'b10);
      @(negedge clk);
      chk("R9 lines released after fault", {scl_oe, sda_oe}, 0);
      slv_sda_low = 1'b0;
      @(negedge clk);
      allow = 1'b0;
   endtask

   task automatic t_fault_data();
      logic [7:0] got; logic s9; longint per, hi;
      allow = 1'b1;
      issue(OP_START, 8'hFF, 1'b0);
      chk("R9 START clears fault", bus_fault, 0);
      @(negedge sda_bus);
      @(posedge scl_bus); #1 slv_sda_low = 1'b1;
      wait_done(60);
      chk("R9 fault on foreign SDA drive", bus_fault, 1);
      @(negedge clk);
      chk("R9 lines released after data fault", {scl_oe, sda_oe}, 0);
      slv_sda_low = 1'b0;
      @(negedge clk);
      allow = 1'b0;
      start_byte(8'hA4, 1'b1, got, s9, per, hi);
      chk("R9 fault cleared by next START", bus_fault, 0);
      chk("R2 byte after recovery", got, 8'hA4);
      stop_seq();
   endtask

   initial begin
      t_reset();
      t_ignore_idle();
      t_write();
      t_read();
      t_fault_start();
      t_fault_data();
      chk("R4 SDA edges while SCL high", r4_viol, 0);
      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule